// File: doc/BRIEF.md
# Down-Counting System Tick Timer

A periodic timer built around a 24-bit down counter, set up by software through a small register bus. Software writes a period into a reload register and selects a count source: every system clock, or only the cycles on which a slower reference strobe is high. Software then enables the timer. Each count tick lowers the counter by one. When the counter has stepped down to zero, the next tick reloads it, so the period is reload + 1 ticks.

Each time the counter steps from one to zero it sets a sticky status flag. It can also raise a single-cycle tick interrupt. Software polls the flag to learn whether a given time has passed since it last looked, because reading the control/status register returns the flag and clears it. Any write to the current-value register clears the counter and the flag, whatever the data.

The counter is run by a three-state sequencer:
- STOP: the timer is disabled and the counter holds.
- WRAP: the timer is enabled and the counter is zero, so the next tick loads the reload value.
- DOWN: the timer is enabled and the counter is non-zero, so each tick decrements it.

The transitions are:
- STOP→WRAP or STOP→DOWN: enable seen set, with the counter zero or non-zero.
- WRAP→DOWN: a tick loads a non-zero reload value.
- WRAP→WRAP: a tick loads a zero reload value.
- DOWN→WRAP: a tick steps the counter from one to zero (a zero crossing).
- Any state→STOP: enable seen clear.
- Any state→WRAP or STOP: a current-value write.

Top module: `tick_timer`

## Requirements
- R1: While enabled and non-zero, the counter decreases by exactly one on each count tick and holds on cycles without a tick.
- R2: A tick that finds the counter at zero loads the reload value (offset 0x4, bits 23:0), so the counter repeats with a period of reload + 1 ticks.
- R3: Any write to the current-value register (offset 0x8) clears the counter to zero and clears the status flag, whatever the written data.
- R4: The status flag (control/status offset 0x0, bit 16) is set on every tick that steps the counter from one to zero.
- R5: A read of the control/status register returns the flag and clears it on that clock edge. If a zero crossing happens on the same edge, the flag stays set.
- R6: When the interrupt enable bit (bit 1) is set, `tick_irq` is high for exactly the one cycle after each zero-crossing edge. When the bit is clear, `tick_irq` stays low.
- R7: When the source-select bit (bit 2) is 1, every clock is a count tick. When it is 0, only cycles with `ref_tick` high are count ticks.
- R8: The enable bit (bit 0) is 0 after reset. While it is 0 the counter holds. After the write that sets it, the first count takes place on the second clock edge. The edge that writes the bit clear may still count.
- R9: With a reload value of zero, the counter stays at zero and the flag is never set.
- R10: After the counter has been cleared, the first tick loads the reload value and neither sets the flag nor raises `tick_irq`.
- R11: Bits 31:24 of the reload and current-value registers read as zero and ignore writes. Offset 0xC reads as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 4 | Byte offset: 0x0 control/status, 0x4 reload, 0x8 current |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle bus_sel is high with bus_wr low |
| ref_tick | input | 1 | Reference count strobe, synchronous to clk |
| tick_irq | output | 1 | Single-cycle tick interrupt request |

## Verification
The assertions take three things for granted about the inputs:
- Each bus access is a single-cycle strobe with a defined address.
- `ref_tick` is a clean signal synchronous to the clock.
- A read and a write never share a cycle, so a flag-clearing read can never meet a current-value write on the same edge.

The bench keeps within these limits. It drives every bus access and every reference pulse one clock after an edge and drops them after the next edge. It never holds two accesses in one cycle. It moves the count source onto the reference strobe whenever exact tick placement matters.

// File: rtl/tick_pkg.sv
package tick_pkg;

    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_WRAP = 2'd1,
        ST_DOWN = 2'd2
    } tick_state_e;

    localparam int OFS_CTRL    = 'h0;
    localparam int OFS_RELOAD  = 'h4;
    localparam int OFS_CURRENT = 'h8;

    localparam int EN_BIT   = 0;
    localparam int TI_BIT   = 1;
    localparam int SRC_BIT  = 2;
    localparam int FLAG_BIT = 16;

endpackage

// File: rtl/tick_src.sv
module tick_src (
    input  logic clk_sel,
    input  logic ref_tick,
    output logic tick
);
    // source select: system clock counts every cycle, else only on strobe
    always_comb begin
        tick = clk_sel ? 1'b1 : ref_tick;
    end
endmodule

// File: rtl/tick_regs.sv
module tick_regs
    import tick_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              wr,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic [CNT_W-1:0]  cnt,
    input  logic              hit,
    output logic              enable,
    output logic              tickint,
    output logic              clk_sel,
    output logic [CNT_W-1:0]  reload,
    output logic              flag,
    output logic              clr_wr
);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_RELD = ADDR_W'(OFS_RELOAD);
    localparam logic [ADDR_W-1:0] A_CURR = ADDR_W'(OFS_CURRENT);

    logic wr_ctrl, wr_reld, rd_ctrl;
    logic wdata_unused;

    assign wr_ctrl = sel && wr && (addr == A_CTRL);
    assign wr_reld = sel && wr && (addr == A_RELD);
    assign clr_wr  = sel && wr && (addr == A_CURR);
    assign rd_ctrl = sel && !wr && (addr == A_CTRL);
    assign wdata_unused = ^wdata[DATA_W-1:CNT_W];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            enable  <= 1'b0;
            tickint <= 1'b0;
            clk_sel <= 1'b0;
            reload  <= '0;
        end else begin
            if (wr_ctrl) begin
                enable  <= wdata[EN_BIT];
                tickint <= wdata[TI_BIT];
                clk_sel <= wdata[SRC_BIT];
            end
            if (wr_reld) begin
                reload <= wdata[CNT_W-1:0];
            end
        end
    end

    // sticky flag: a clearing write beats a crossing, a crossing beats a read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag <= 1'b0;
        end else if (clr_wr) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (rd_ctrl) begin
            flag <= 1'b0;
        end
    end

    always_comb begin
        rdata = '0;
        if (sel && !wr) begin
            if (addr == A_CTRL) begin
                rdata[EN_BIT]   = enable;
                rdata[TI_BIT]   = tickint;
                rdata[SRC_BIT]  = clk_sel;
                rdata[FLAG_BIT] = flag;
            end else if (addr == A_RELD) begin
                rdata[CNT_W-1:0] = reload;
            end else if (addr == A_CURR) begin
                rdata[CNT_W-1:0] = cnt;
            end
        end
    end
endmodule

// File: rtl/tick_fsm.sv
module tick_fsm
    import tick_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             enable,
    input  logic             tick,
    input  logic             tickint,
    input  logic             clr,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] cnt,
    output logic             counting,
    output logic             hit,
    output logic             irq
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    tick_state_e      st_q, st_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             irq_q;

    assign counting = enable && tick && (st_q != ST_STOP);

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        hit   = 1'b0;
        if (clr) begin
            cnt_n = '0;
            st_n  = enable ? ST_WRAP : ST_STOP;
        end else begin
            unique case (st_q)
                ST_STOP: begin
                    if (enable) begin
                        st_n = (cnt_q == '0) ? ST_WRAP : ST_DOWN;
                    end
                end
                ST_WRAP: begin
                    if (!enable) begin
                        st_n = ST_STOP;
                    end else if (counting) begin
                        cnt_n = reload;
                        st_n  = (reload == '0) ? ST_WRAP : ST_DOWN;
                    end
                end
                ST_DOWN: begin
                    if (!enable) begin
                        st_n = ST_STOP;
                    end else if (counting) begin
                        cnt_n = cnt_q - ONE;
                        if (cnt_q == ONE) begin
                            hit  = 1'b1;
                            st_n = ST_WRAP;
                        end
                    end
                end
                default: st_n = ST_STOP;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_STOP;
            cnt_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= hit && tickint;
        end
    end

    assign cnt = cnt_q;
    assign irq = irq_q;
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              ref_tick,
    output logic              tick_irq
);
    logic             enable, tickint, clk_sel, flag, clr_wr;
    logic             tick, counting, hit;
    logic [CNT_W-1:0] reload, cnt;

    tick_src u_src (
        .clk_sel (clk_sel),
        .ref_tick(ref_tick),
        .tick    (tick)
    );

    tick_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .sel    (bus_sel),
        .wr     (bus_wr),
        .addr   (bus_addr),
        .wdata  (bus_wdata),
        .rdata  (bus_rdata),
        .cnt    (cnt),
        .hit    (hit),
        .enable (enable),
        .tickint(tickint),
        .clk_sel(clk_sel),
        .reload (reload),
        .flag   (flag),
        .clr_wr (clr_wr)
    );

    tick_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (enable),
        .tick    (tick),
        .tickint (tickint),
        .clr     (clr_wr),
        .reload  (reload),
        .cnt     (cnt),
        .counting(counting),
        .hit     (hit),
        .irq     (tick_irq)
    );
endmodule

// File: rtl/tick_timer_chk.sv
module tick_timer_chk
    import tick_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 24,
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sel,
    input logic              wr,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rdata,
    input logic [CNT_W-1:0]  cnt,
    input logic [CNT_W-1:0]  reload,
    input logic              flag,
    input logic              irq,
    input logic              counting,
    input logic              clr_wr,
    input logic              enable,
    input logic              tickint
);
    localparam logic [CNT_W-1:0]  ONE    = CNT_W'(1);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);

    p_dec_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !clr_wr && cnt != '0) |=> cnt == $past(cnt) - ONE);

    p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !clr_wr && cnt == '0) |=> cnt == $past(reload));

    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        clr_wr |=> (cnt == '0 && !flag));

    p_flag_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (counting && !clr_wr && cnt == ONE) |=> flag);

    p_read_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && addr == A_CTRL && !(counting && cnt == ONE)) |=> !flag);

    p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    p_irq_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cnt == '0 && $past(tickint)));

    p_hold_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clr_wr) |=> $stable(cnt));

    p_upper_zero_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (sel && !wr && addr != A_CTRL) |-> rdata[DATA_W-1:CNT_W] == '0);
endmodule

bind tick_timer tick_timer_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sel     (bus_sel),
    .wr      (bus_wr),
    .addr    (bus_addr),
    .rdata   (bus_rdata),
    .cnt     (cnt),
    .reload  (reload),
    .flag    (flag),
    .irq     (tick_irq),
    .counting(counting),
    .clr_wr  (clr_wr),
    .enable  (enable),
    .tickint (tickint)
);

// File: tb/sim_tick_timer.sv
`timescale 1ns/1ps
module sim_tick_timer;
    localparam logic [3:0] A_CTRL = 4'h0;
    localparam logic [3:0] A_RELD = 4'h4;
    localparam logic [3:0] A_CURR = 4'h8;
    localparam logic [3:0] A_NONE = 4'hC;
    localparam logic [31:0] FLAG  = 32'h0001_0000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        ref_tick = 1'b0;
    logic        tick_irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    tick_timer u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata),
        .ref_tick (ref_tick),
        .tick_irq (tick_irq)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic bwrite(input logic [3:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bread(input logic [3:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk); #1;
        bus_sel = 1'b0;
    endtask

    task automatic pulse();
        ref_tick = 1'b1;
        @(posedge clk); #1;
        ref_tick = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    // disable, clear counter and flag, set reload
    task automatic setup(input logic [31:0] rl);
        logic [31:0] d;
        bwrite(A_CTRL, 32'h0);
        bwrite(A_CURR, 32'h0);
        bwrite(A_RELD, rl);
        bread(A_CTRL, d);
    endtask

    task automatic enable_ref(input logic [31:0] ctrl);
        bwrite(A_CTRL, ctrl);
        idle(1);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R8 reset irq", {31'b0, tick_irq}, 32'h0);
        bread(A_CTRL, d); check("R8 reset ctrl", d, 32'h0);
        bread(A_RELD, d); check("R2 reset reload", d, 32'h0);
        bread(A_CURR, d); check("R1 reset current", d, 32'h0);
    endtask

    task automatic t_count_ref();
        logic [31:0] d;
        setup(32'd3);
        enable_ref(32'h3);
        pulse();
        bread(A_CURR, d); check("R10 first tick loads", d, 32'd3);
        bread(A_CTRL, d); check("R10 no flag on load", d, 32'h3);
        check("R10 no irq on load", {31'b0, tick_irq}, 32'h0);
        pulse();
        bread(A_CURR, d); check("R1 dec 3->2", d, 32'd2);
        idle(3);
        bread(A_CURR, d); check("R7 hold without ref_tick", d, 32'd2);
        pulse();
        pulse();
        check("R6 irq after crossing", {31'b0, tick_irq}, 32'h1);
        idle(1);
        check("R6 irq one cycle", {31'b0, tick_irq}, 32'h0);
        bread(A_CURR, d); check("R1 reached zero", d, 32'd0);
        bread(A_CTRL, d); check("R4 flag set", d, FLAG | 32'h3);
        bread(A_CTRL, d); check("R5 flag cleared by read", d, 32'h3);
        pulse();
        bread(A_CURR, d); check("R2 wrap reload", d, 32'd3);
    endtask

    task automatic t_no_irq();
        logic [31:0] d;
        setup(32'd1);
        enable_ref(32'h1);
        pulse();
        pulse();
        check("R6 no irq when disabled", {31'b0, tick_irq}, 32'h0);
        idle(1);
        check("R6 still no irq", {31'b0, tick_irq}, 32'h0);
        bread(A_CTRL, d); check("R4 flag without irq", d, FLAG | 32'h1);
    endtask

    task automatic t_clear_write();
        logic [31:0] d;
        setup(32'd2);
        enable_ref(32'h1);
        pulse(); pulse(); pulse(); pulse();
        bread(A_CURR, d); check("R2 period reload+1", d, 32'd2);
        bwrite(A_CURR, 32'h00AB_CDEF);
        bread(A_CURR, d); check("R3 write clears counter", d, 32'd0);
        bread(A_CTRL, d); check("R3 write clears flag", d, 32'h1);
        pulse();
        bread(A_CURR, d); check("R10 load after clear", d, 32'd2);
        bread(A_CTRL, d); check("R10 no flag after clear", d, 32'h1);
    endtask

    task automatic t_read_vs_hit();
        logic [31:0] d;
        setup(32'd1);
        enable_ref(32'h1);
        pulse();
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = A_CTRL; ref_tick = 1'b1;
        #1 d = bus_rdata;
        check("R5 read before crossing", d, 32'h1);
        @(posedge clk); #1;
        bus_sel = 1'b0; ref_tick = 1'b0;
        bread(A_CTRL, d); check("R5 crossing wins over read", d, FLAG | 32'h1);
        bread(A_CTRL, d); check("R5 cleared after", d, 32'h1);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        setup(32'd5);
        enable_ref(32'h1);
        pulse();
        bwrite(A_CTRL, 32'h0);
        pulse(); pulse();
        bread(A_CURR, d); check("R8 hold while disabled", d, 32'd5);
        bwrite(A_CTRL, 32'h4);
        idle(3);
        bread(A_CURR, d); check("R8 hold with sysclk disabled", d, 32'd5);
        bwrite(A_CTRL, 32'h5);
        bread(A_CURR, d); check("R8 no count at first edge", d, 32'd5);
        bread(A_CURR, d); check("R8 no count before second edge", d, 32'd5);
        bread(A_CURR, d); check("R7 sysclk count", d, 32'd4);
        bread(A_CURR, d); check("R7 sysclk every cycle", d, 32'd3);
        bwrite(A_CTRL, 32'h0);
        bread(A_CURR, d); check("R8 stopped", d, 32'd1);
        bread(A_CURR, d); check("R8 stays stopped", d, 32'd1);
    endtask

    task automatic t_reload_zero();
        logic [31:0] d;
        setup(32'd0);
        enable_ref(32'h3);
        pulse(); pulse(); pulse();
        check("R9 no irq", {31'b0, tick_irq}, 32'h0);
        bread(A_CURR, d); check("R9 stays zero", d, 32'd0);
        bread(A_CTRL, d); check("R9 no flag", d, 32'h3);
    endtask

    task automatic t_upper();
        logic [31:0] d;
        bwrite(A_CTRL, 32'h0);
        bwrite(A_RELD, 32'hFF12_3456);
        bread(A_RELD, d); check("R11 reload upper bits", d, 32'h0012_3456);
        bwrite(A_CURR, 32'hFFFF_FFFF);
        bread(A_CURR, d); check("R11 current upper bits", d, 32'h0);
        bread(A_NONE, d); check("R11 unused offset", d, 32'h0);
    endtask

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(1);
        t_reset();
        t_count_ref();
        t_no_irq();
        t_clear_write();
        t_read_vs_hit();
        t_enable();
        t_reload_zero();
        t_upper();
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule